// File: doc/BRIEF.md
# Processor Sideband Signal Controller

This block drives the active-low control lines that an I/O hub sends to a processor. It turns an initialization request from any of several sources into a low pulse on `init_n` that lasts a fixed number of bus clocks. The count of that pulse is frozen while the stop-clock request to the processor (`stop_clk_n`) is asserted. A request that arrives while stop-clock is asserted is held and starts its pulse only once stop-clock is released.

The block also produces the address-line-20 mask output `a20_mask_n`. It combines one bit of an 8-bit software register, written through a single-cycle port-write strobe, with an external gate input. While processor reset (`cpu_rst_n`) is low, a set of shared outputs carries the frequency-strap values. After reset releases they switch back to their normal functional values. Every output is a flip-flop that drives both levels.

Top module: `cpu_sideband_ctl`

## Requirements
- R1: A request sampled at a clock edge while `stop_clk_n` is high drives `init_n` low from that edge. With no stop-clock, `init_n` stays low for exactly PULSE_LEN (16) clock cycles and then returns high.
- R2: The bits of `init_req` are ORed. A request on any single source bit produces the same pulse.
- R3: A request seen while a pulse is in progress neither restarts nor extends the pulse. The total low time stays PULSE_LEN cycles.
- R4: At each edge where `stop_clk_n` is low, the pulse count does not advance. The total low time equals PULSE_LEN plus the number of stopped edges that fall inside the pulse.
- R5: A request sampled while `stop_clk_n` is low is latched, even if it lasts only one cycle. `init_n` stays high until the first edge that samples `stop_clk_n` high. `init_n` goes low at that edge, and a full PULSE_LEN pulse follows.
- R6: While `rst` is high, `init_n` is high and any latched deferred request is discarded.
- R7: `a20_mask_n` is low only when register bit 1 is 0 and `a20_gate_in` is 0. It is high otherwise. The output reflects the inputs sampled at the previous edge.
- R8: The mask register resets to 0. A write with `port_wr` high loads `port_wdata`, and the new bit 1 takes effect on `a20_mask_n` at that same edge. The other data bits have no effect on the output.
- R9: While `cpu_rst_n` is low (and during `rst`), `shared_out` carries `strap_val`. At the first edge that samples `cpu_rst_n` high, `shared_out` still carries `strap_val`. From the second such edge onward, it carries `func_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | NUM_SRC | Initialization event requests, one per source |
| stop_clk_n | input | 1 | Stop-clock request to the processor, active low |
| a20_gate_in | input | 1 | External address-line-20 gate |
| port_wr | input | 1 | Single-cycle write strobe for the mask register |
| port_wdata | input | DATA_W | Write data for the mask register |
| cpu_rst_n | input | 1 | Processor reset, active low |
| strap_val | input | STRAP_W | Frequency strap values held during processor reset |
| func_val | input | STRAP_W | Normal functional values of the shared outputs |
| init_n | output | 1 | Processor initialization line, active low |
| a20_mask_n | output | 1 | Address-line-20 mask, active low |
| shared_out | output | STRAP_W | Shared outputs carrying straps or functional values |

## Verification
On every cycle, the assertions check four things. A pulse never starts after a stopped edge. `init_n` cannot change across a stopped edge. Every completed pulse contains exactly PULSE_LEN running edges. The mask output and the shared outputs follow the gate and the strap values sampled one edge earlier. Some behaviours appear only in the bench scenarios: a request that arrives mid-pulse is dropped, a one-cycle request during stop-clock is latched, a reset discards a latched request, and the register data bits other than bit 1 have no effect.

// File: rtl/cpu_sb_pkg.sv
package cpu_sb_pkg;

  typedef enum logic [1:0] {
    INIT_IDLE  = 2'd0,
    INIT_DEFER = 2'd1,
    INIT_PULSE = 2'd2
  } init_state_e;

endpackage

// File: rtl/sb_init_stretch.sv
module sb_init_stretch
  import cpu_sb_pkg::*;
#(
  parameter int NUM_SRC   = 4,
  parameter int PULSE_LEN = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req,
  input  logic               stop_n,
  output logic               init_n
);

  localparam int CNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_LEN - 1);

  init_state_e      st;
  logic [CNT_W-1:0] cnt;
  logic             any_req;

  assign any_req = |req;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= INIT_IDLE;
      cnt    <= '0;
      init_n <= 1'b1;
    end else begin
      case (st)
        INIT_IDLE: begin
          if (any_req) begin
            if (!stop_n) begin
              st <= INIT_DEFER;
            end else begin
              st     <= INIT_PULSE;
              cnt    <= '0;
              init_n <= 1'b0;
            end
          end
        end
        INIT_DEFER: begin
          if (stop_n) begin
            st     <= INIT_PULSE;
            cnt    <= '0;
            init_n <= 1'b0;
          end
        end
        INIT_PULSE: begin
          if (stop_n) begin
            if (cnt == LAST) begin
              st     <= INIT_IDLE;
              init_n <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: begin
          st     <= INIT_IDLE;
          init_n <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/sb_a20_mask.sv
module sb_a20_mask (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic wr_bit,
  input  logic gate,
  output logic mask_n
);

  logic alt_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      alt_bit <= 1'b0;
      mask_n  <= gate;
    end else begin
      if (wr) alt_bit <= wr_bit;
      mask_n <= (wr ? wr_bit : alt_bit) | gate;
    end
  end

endmodule

// File: rtl/sb_strap_hold.sv
module sb_strap_hold #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_rst_n,
  input  logic [WIDTH-1:0] strap,
  input  logic [WIDTH-1:0] func,
  output logic [WIDTH-1:0] out
);

  logic rel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_q <= 1'b0;
      out   <= strap;
    end else begin
      rel_q <= cpu_rst_n;
      out   <= (cpu_rst_n && rel_q) ? func : strap;
    end
  end

endmodule

// File: rtl/cpu_sideband_ctl.sv
module cpu_sideband_ctl #(
  parameter int NUM_SRC   = 4,
  parameter int PULSE_LEN = 16,
  parameter int DATA_W    = 8,
  parameter int MASK_BIT  = 1,
  parameter int STRAP_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] init_req,
  input  logic               stop_clk_n,
  input  logic               a20_gate_in,
  input  logic               port_wr,
  input  logic [DATA_W-1:0]  port_wdata,
  input  logic               cpu_rst_n,
  input  logic [STRAP_W-1:0] strap_val,
  input  logic [STRAP_W-1:0] func_val,
  output logic               init_n,
  output logic               a20_mask_n,
  output logic [STRAP_W-1:0] shared_out
);

  logic unused_wdata;
  assign unused_wdata = ^port_wdata;

  sb_init_stretch #(
    .NUM_SRC  (NUM_SRC),
    .PULSE_LEN(PULSE_LEN)
  ) u_init (
    .clk   (clk),
    .rst   (rst),
    .req   (init_req),
    .stop_n(stop_clk_n),
    .init_n(init_n)
  );

  sb_a20_mask u_a20 (
    .clk   (clk),
    .rst   (rst),
    .wr    (port_wr),
    .wr_bit(port_wdata[MASK_BIT]),
    .gate  (a20_gate_in),
    .mask_n(a20_mask_n)
  );

  sb_strap_hold #(
    .WIDTH(STRAP_W)
  ) u_strap (
    .clk      (clk),
    .rst      (rst),
    .cpu_rst_n(cpu_rst_n),
    .strap    (strap_val),
    .func     (func_val),
    .out      (shared_out)
  );

endmodule

// File: rtl/cpu_sideband_chk.sv
module cpu_sideband_chk #(
  parameter int PULSE_LEN = 16,
  parameter int STRAP_W   = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               stop_clk_n,
  input logic               init_n,
  input logic               a20_gate_in,
  input logic               a20_mask_n,
  input logic               cpu_rst_n,
  input logic [STRAP_W-1:0] strap_val,
  input logic [STRAP_W-1:0] shared_out
);

  // Running edges seen while init_n is low
  logic [15:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || init_n) run_cnt <= '0;
    else if (stop_clk_n) run_cnt <= run_cnt + 16'd1;
  end

  // R5: no pulse begins at an edge that sampled stop-clock asserted
  assert_no_start_stopped_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(init_n) |-> $past(stop_clk_n));

  // R4: init_n cannot change across a stopped edge
  assert_frozen_when_stopped_R4: assert property (@(posedge clk) disable iff (rst)
    !stop_clk_n |=> $stable(init_n));

  // R1: a completed pulse holds exactly PULSE_LEN running edges
  assert_pulse_length_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(init_n) |-> (run_cnt == 16'(PULSE_LEN)));

  // R7: a high gate forces the mask inactive one edge later
  assert_gate_unmasks_R7: assert property (@(posedge clk) disable iff (rst)
    a20_gate_in |=> a20_mask_n);

  // R9: straps are driven while processor reset is low
  assert_strap_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !cpu_rst_n |=> (shared_out == $past(strap_val)));

endmodule

bind cpu_sideband_ctl cpu_sideband_chk #(
  .PULSE_LEN(PULSE_LEN),
  .STRAP_W  (STRAP_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .stop_clk_n (stop_clk_n),
  .init_n     (init_n),
  .a20_gate_in(a20_gate_in),
  .a20_mask_n (a20_mask_n),
  .cpu_rst_n  (cpu_rst_n),
  .strap_val  (strap_val),
  .shared_out (shared_out)
);

// File: tb/cpu_sideband_ctl_tb.sv
`timescale 1ns/1ps
module cpu_sideband_ctl_tb;

  localparam int NUM_SRC = 4;
  localparam int PLEN    = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_SRC-1:0] init_req = '0;
  logic stop_clk_n = 1'b1;
  logic a20_gate_in = 1'b0;
  logic port_wr = 1'b0;
  logic [7:0] port_wdata = '0;
  logic cpu_rst_n = 1'b0;
  logic [1:0] strap_val = 2'b10;
  logic [1:0] func_val = 2'b01;
  logic init_n, a20_mask_n;
  logic [1:0] shared_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cpu_sideband_ctl u_dut (
    .clk(clk), .rst(rst), .init_req(init_req), .stop_clk_n(stop_clk_n),
    .a20_gate_in(a20_gate_in), .port_wr(port_wr), .port_wdata(port_wdata),
    .cpu_rst_n(cpu_rst_n), .strap_val(strap_val), .func_val(func_val),
    .init_n(init_n), .a20_mask_n(a20_mask_n), .shared_out(shared_out)
  );

  // {wr, data[7:0], gate, expected mask_n}
  localparam logic [10:0] VEC [8] = '{
    {1'b0, 8'h00, 1'b0, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b1},
    {1'b1, 8'h02, 1'b0, 1'b1},
    {1'b0, 8'h00, 1'b0, 1'b1},
    {1'b1, 8'hFD, 1'b0, 1'b0},
    {1'b1, 8'h02, 1'b1, 1'b1},
    {1'b1, 8'h00, 1'b1, 1'b1},
    {1'b0, 8'hFF, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Called at the negedge where init_n is first seen low
  task automatic count_low(output int n);
    n = 0;
    while (init_n == 1'b0 && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int len;
    int stayed;
    @(negedge clk); @(negedge clk);
    chk("R6 reset init_n high", init_n, 1);
    chk("R8 reset mask low (reg 0, gate 0)", a20_mask_n, 0);
    chk("R9 straps during reset", shared_out, 2'b10);
    rst = 1'b0;
    @(negedge clk);

    // Mask table walk
    foreach (VEC[i]) begin
      port_wr     = VEC[i][10];
      port_wdata  = VEC[i][9:2];
      a20_gate_in = VEC[i][1];
      @(negedge clk);
      chk($sformatf("R7/R8 mask vector %0d", i), a20_mask_n, VEC[i][0]);
    end
    port_wr = 1'b0; a20_gate_in = 1'b0;

    // R1: basic pulse
    init_req = 4'b0001;
    @(negedge clk);
    init_req = '0;
    chk("R1 init_n low after request", init_n, 0);
    count_low(len);
    chk("R1 pulse length", len, PLEN);

    // R2: other source
    cycles(3);
    init_req = 4'b1000;
    @(negedge clk);
    init_req = '0;
    count_low(len);
    chk("R2 source 3 pulse length", len, PLEN);

    // R3: request during pulse ignored
    cycles(2);
    init_req = 4'b0010;
    @(negedge clk);
    init_req = '0;
    cycles(4);
    init_req = 4'b0100;
    @(negedge clk);
    init_req = '0;
    count_low(len);
    chk("R3 mid-pulse request no extension", len + 5, PLEN);
    cycles(3);
    chk("R3 no restart afterwards", init_n, 1);

    // R4: stop-clock freezes count
    init_req = 4'b0001;
    @(negedge clk);
    init_req = '0;
    cycles(3);
    stop_clk_n = 1'b0;
    cycles(6);
    stop_clk_n = 1'b1;
    count_low(len);
    chk("R4 pulse stretched by stopped edges", len + 9, PLEN + 6);

    // R5: deferred request
    cycles(2);
    stop_clk_n = 1'b0;
    @(negedge clk);
    init_req = 4'b0100;
    @(negedge clk);
    init_req = '0;
    stayed = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (init_n == 1'b0) stayed = 0;
    end
    chk("R5 held high during stop-clock", stayed, 1);
    stop_clk_n = 1'b1;
    @(negedge clk);
    chk("R5 falls at release edge", init_n, 0);
    count_low(len);
    chk("R5 deferred pulse length", len, PLEN);

    // R6: reset discards pending request
    cycles(2);
    stop_clk_n = 1'b0;
    init_req = 4'b0001;
    @(negedge clk);
    init_req = '0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    stop_clk_n = 1'b1;
    stayed = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (init_n == 1'b0) stayed = 0;
    end
    chk("R6 pending request discarded", stayed, 1);

    // R9: strap release timing
    cpu_rst_n = 1'b0;
    cycles(2);
    chk("R9 straps while cpu reset low", shared_out, 2'b10);
    cpu_rst_n = 1'b1;
    @(negedge clk);
    chk("R9 straps at first release edge", shared_out, 2'b10);
    @(negedge clk);
    chk("R9 functional after second edge", shared_out, 2'b01);
    func_val = 2'b11;
    @(negedge clk);
    chk("R9 functional value follows", shared_out, 2'b11);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule